// File: doc/BRIEF.md
# In-Order Packet Completion Tracker

This block sits beside a receive DMA engine that writes packets to memory. Each packet gets a slot in a small circular table when its free descriptor is fetched, and the slot number becomes the packet's tag. The engine reports every memory write it issues under that tag and flags the final write of the packet. The memory side returns a write-status response for each write under the same tag. A descriptor pointer goes to the completion queue only after every write of its packet has been acknowledged. Pointers leave strictly in the order their slots were allocated, even when responses come back out of order.

Channels that do not run in pass-by-reference mode take no part in the tracking. Their pointers come in on a separate bypass input. They are forwarded on the same return output in any cycle where no tracked packet is retiring.

Top module: `pkt_order_tracker`

## Requirements
- R1: Slot tags are handed out in circular order 0, 1, ..., DEPTH-1, 0, ... starting from 0 after reset, and `alloc_id` shows the tag the next accepted allocation will receive.
- R2: `alloc_ready` is low exactly while DEPTH packets are held, and an allocation offered then is not taken.
- R3: A tracked packet is presented on the return output only when it is the oldest held packet, its final write has been issued, and every issued write has received a response. It is presented in the same cycle those conditions first hold.
- R4: Tracked pointers leave in allocation order, at most one per cycle, each carrying the pointer value supplied when its slot was allocated.
- R5: A write issue and a write response for the same slot in the same cycle leave that slot's outstanding count unchanged.
- R6: A response with `st_err` high marks its packet. That packet still retires in order, with `ret_err` high. Packets without an error response retire with `ret_err` low.
- R7: In a cycle with no tracked retirement, a bypass pointer offered on `byp_valid` appears on the return output in the same cycle with `ret_bypass` high and `ret_err` low. In a cycle with a tracked retirement, `byp_ready` is low and the tracked pointer wins.
- R8: After reset, no packet is held, `alloc_ready` is high, `alloc_id` is 0 and `ret_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot for a newly fetched descriptor |
| alloc_ptr | input | PTR_W | Descriptor pointer stored in the slot |
| alloc_ready | output | 1 | High when a slot is free |
| alloc_id | output | ID_W | Tag the next allocation receives |
| wr_valid | input | 1 | The engine issued one write for a tracked packet |
| wr_id | input | ID_W | Tag of that write |
| wr_last | input | 1 | That write is the packet's final write |
| st_valid | input | 1 | A write-status response arrived |
| st_id | input | ID_W | Tag of the response |
| st_err | input | 1 | The response reports an error |
| byp_valid | input | 1 | Pointer from an untracked channel offered |
| byp_ptr | input | PTR_W | Untracked pointer |
| byp_ready | output | 1 | Bypass pointer taken this cycle |
| ret_valid | output | 1 | A pointer is returned this cycle |
| ret_ptr | output | PTR_W | Returned pointer |
| ret_err | output | 1 | Returned tracked packet saw an error response |
| ret_bypass | output | 1 | Returned pointer came from the bypass input |

## Verification
The bench builds the tracker with DEPTH=4, PTR_W=16 and CNT_W=3. The small table fills after four allocations, so the full condition, head and tail wrap-around, and allocation in the same cycle as a retirement all occur many times in a short run. A three-bit counter lets per-packet outstanding writes reach six, close to the counter's top value. Responses are returned in random order across held packets, so a younger packet often finishes before an older one and has to wait behind it.

// File: rtl/pot_pkg.sv
package pot_pkg;

    localparam int unsigned POT_DEPTH = 8;
    localparam int unsigned POT_PTR_W = 32;
    localparam int unsigned POT_CNT_W = 6;

    // Where the return output takes its value from in a cycle
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_ORDERED = 2'd1,
        SRC_BYPASS  = 2'd2
    } ret_src_e;

    // Circular successor of a slot index
    function automatic int unsigned ring_next(int unsigned v, int unsigned depth);
        return (v + 1 == depth) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/pot_entry.sv
module pot_entry
    import pot_pkg::*;
#(
    parameter int unsigned PTR_W = POT_PTR_W,
    parameter int unsigned CNT_W = POT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             inc,
    input  logic             dec,
    input  logic             mark_last,
    input  logic             mark_err,
    input  logic             release_i,
    output logic             busy,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             err,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ptr  <= '0;
            cnt  <= '0;
            last <= 1'b0;
            err  <= 1'b0;
        end else if (load) begin
            busy <= 1'b1;
            ptr  <= load_ptr;
            cnt  <= '0;
            last <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (release_i) busy <= 1'b0;
            case ({inc, dec})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
            if (mark_last) last <= 1'b1;
            if (mark_err)  err  <= 1'b1;
        end
    end

    assign done = busy && last && (cnt == '0);

    // R5: simultaneous issue and response keep the count
    a_r5_inc_dec_balance: assert property (@(posedge clk) disable iff (rst)
        (inc && dec && !load) |=> $stable(cnt));

    // R5: a response never arrives for a slot with nothing outstanding
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |-> (cnt != '0));

    // R6: an error mark persists until the slot is reloaded
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !load) |=> err);

endmodule

// File: rtl/pot_ring.sv
module pot_ring
    import pot_pkg::*;
#(
    parameter int unsigned DEPTH = POT_DEPTH,
    localparam int unsigned ID_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    output logic [ID_W-1:0] head,
    output logic [ID_W-1:0] tail,
    output logic            full
);

    logic [OCC_W-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) tail <= ID_W'(ring_next(int'(tail), DEPTH));
            if (pop)  head <= ID_W'(ring_next(int'(head), DEPTH));
            case ({push, pop})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
        end
    end

    assign full = (occ == OCC_W'(DEPTH));

    // R2: occupancy never exceeds the table size
    a_r2_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    // R4: each retirement moves the head by exactly one slot
    a_r4_head_step: assert property (@(posedge clk) disable iff (rst)
        pop |=> (head == ID_W'(ring_next(int'($past(head)), DEPTH))));

endmodule

// File: rtl/pot_ret_mux.sv
module pot_ret_mux
    import pot_pkg::*;
#(
    parameter int unsigned PTR_W = POT_PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ord_ok,
    input  logic [PTR_W-1:0] ord_ptr,
    input  logic             ord_err,
    input  logic             byp_valid,
    input  logic [PTR_W-1:0] byp_ptr,
    output logic             byp_ready,
    output logic             ret_valid,
    output logic [PTR_W-1:0] ret_ptr,
    output logic             ret_err,
    output logic             ret_bypass
);

    ret_src_e src;

    always_comb begin
        if (ord_ok)         src = SRC_ORDERED;
        else if (byp_valid) src = SRC_BYPASS;
        else                src = SRC_NONE;
    end

    always_comb begin
        ret_valid  = (src != SRC_NONE);
        ret_bypass = (src == SRC_BYPASS);
        byp_ready  = (src != SRC_ORDERED);
        ret_err    = (src == SRC_ORDERED) && ord_err;
        ret_ptr    = (src == SRC_BYPASS) ? byp_ptr : ord_ptr;
    end

    // R7: a bypass return carries the offered pointer and no error
    a_r7_bypass_clean: assert property (@(posedge clk) disable iff (rst)
        ret_bypass |-> (byp_valid && !ret_err && ret_ptr == byp_ptr));

endmodule

// File: rtl/pkt_order_tracker.sv
module pkt_order_tracker
    import pot_pkg::*;
#(
    parameter int unsigned DEPTH = POT_DEPTH,
    parameter int unsigned PTR_W = POT_PTR_W,
    parameter int unsigned CNT_W = POT_CNT_W,
    localparam int unsigned ID_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  logic [PTR_W-1:0] alloc_ptr,
    output logic             alloc_ready,
    output logic [ID_W-1:0]  alloc_id,
    input  logic             wr_valid,
    input  logic [ID_W-1:0]  wr_id,
    input  logic             wr_last,
    input  logic             st_valid,
    input  logic [ID_W-1:0]  st_id,
    input  logic             st_err,
    input  logic             byp_valid,
    input  logic [PTR_W-1:0] byp_ptr,
    output logic             byp_ready,
    output logic             ret_valid,
    output logic [PTR_W-1:0] ret_ptr,
    output logic             ret_err,
    output logic             ret_bypass
);

    logic [ID_W-1:0]  head, tail;
    logic             full, push, retire;
    logic [DEPTH-1:0] ld, inc, dec, mlast, merr, rel;
    logic [DEPTH-1:0] e_busy, e_last, e_err, e_done;
    logic [PTR_W-1:0] e_ptr [DEPTH];
    logic [CNT_W-1:0] e_cnt [DEPTH];

    assign alloc_ready = !full;
    assign alloc_id    = tail;
    assign push        = alloc_valid && !full;
    assign retire      = e_done[head];

    pot_ring #(.DEPTH(DEPTH)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .pop  (retire),
        .head (head),
        .tail (tail),
        .full (full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign ld[i]    = push && (tail == ID_W'(i));
        assign inc[i]   = wr_valid && (wr_id == ID_W'(i));
        assign mlast[i] = inc[i] && wr_last;
        assign dec[i]   = st_valid && (st_id == ID_W'(i));
        assign merr[i]  = dec[i] && st_err;
        assign rel[i]   = retire && (head == ID_W'(i));

        pot_entry #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .load      (ld[i]),
            .load_ptr  (alloc_ptr),
            .inc       (inc[i]),
            .dec       (dec[i]),
            .mark_last (mlast[i]),
            .mark_err  (merr[i]),
            .release_i (rel[i]),
            .busy      (e_busy[i]),
            .ptr       (e_ptr[i]),
            .cnt       (e_cnt[i]),
            .last      (e_last[i]),
            .err       (e_err[i]),
            .done      (e_done[i])
        );
    end

    pot_ret_mux #(.PTR_W(PTR_W)) u_mux (
        .clk        (clk),
        .rst        (rst),
        .ord_ok     (retire),
        .ord_ptr    (e_ptr[head]),
        .ord_err    (e_err[head]),
        .byp_valid  (byp_valid),
        .byp_ptr    (byp_ptr),
        .byp_ready  (byp_ready),
        .ret_valid  (ret_valid),
        .ret_ptr    (ret_ptr),
        .ret_err    (ret_err),
        .ret_bypass (ret_bypass)
    );

    // R3: a tracked return only for a finished packet at the head
    a_r3_retire_gate: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_bypass) |->
            (e_busy[head] && e_last[head] && e_cnt[head] == '0));

    // R4: at most one slot released per cycle
    a_r4_single_release: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rel));

    // R7: bypass refused while a tracked packet retires
    a_r7_ordered_first: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_bypass) |-> !byp_ready);

endmodule

// File: tb/pkt_order_tracker_tb.sv
`timescale 1ns/1ps
module pkt_order_tracker_tb;

    localparam int DEPTH = 4;
    localparam int PTR_W = 16;
    localparam int CNT_W = 3;
    localparam int ID_W  = 2;
    localparam int MAXO  = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             alloc_valid = 1'b0;
    logic [PTR_W-1:0] alloc_ptr = '0;
    logic             alloc_ready;
    logic [ID_W-1:0]  alloc_id;
    logic             wr_valid = 1'b0;
    logic [ID_W-1:0]  wr_id = '0;
    logic             wr_last = 1'b0;
    logic             st_valid = 1'b0;
    logic [ID_W-1:0]  st_id = '0;
    logic             st_err = 1'b0;
    logic             byp_valid = 1'b0;
    logic [PTR_W-1:0] byp_ptr = '0;
    logic             byp_ready;
    logic             ret_valid;
    logic [PTR_W-1:0] ret_ptr;
    logic             ret_err;
    logic             ret_bypass;

    always #4 clk = ~clk;

    pkt_order_tracker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dut (.*);

    int checks = 0;
    int fails  = 0;

    // behavioural model
    int   m_order[$];
    int   m_tail = 0;
    int   m_cnt [DEPTH];
    bit   m_last[DEPTH];
    bit   m_err [DEPTH];
    logic [PTR_W-1:0] m_ptr[DEPTH];

    task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // one cycle with explicit inputs: drive, compare, advance model
    task automatic step_fixed(bit av, logic [PTR_W-1:0] ap,
                              bit wv, int wid, bit wl,
                              bit sv, int sid, bit se,
                              bit bv, logic [PTR_W-1:0] bp);
        bit full_e, ret_e;
        int h;
        alloc_valid = av; alloc_ptr = ap;
        wr_valid = wv; wr_id = ID_W'(wid); wr_last = wl;
        st_valid = sv; st_id = ID_W'(sid); st_err = se;
        byp_valid = bv; byp_ptr = bp;
        #1;
        full_e = (m_order.size() == DEPTH);
        h      = (m_order.size() > 0) ? m_order[0] : 0;
        ret_e  = (m_order.size() > 0) && m_last[h] && (m_cnt[h] == 0);
        chk("R2", "alloc_ready", alloc_ready, !full_e);
        chk("R1", "alloc_id", alloc_id, m_tail);
        chk("R3", "ret_valid", ret_valid, ret_e || bv);
        chk("R7", "byp_ready", byp_ready, !ret_e);
        chk("R7", "ret_bypass", ret_bypass, !ret_e && bv);
        if (ret_e) begin
            chk("R4", "ret_ptr", ret_ptr, m_ptr[h]);
            chk("R6", "ret_err", ret_err, m_err[h]);
        end else if (bv) begin
            chk("R7", "ret_ptr", ret_ptr, bp);
            chk("R7", "ret_err", ret_err, 0);
        end
        @(posedge clk);
        if (ret_e) void'(m_order.pop_front());
        if (av && !full_e) begin
            m_order.push_back(m_tail);
            m_ptr[m_tail] = ap; m_cnt[m_tail] = 0;
            m_last[m_tail] = 0; m_err[m_tail] = 0;
            m_tail = (m_tail + 1) % DEPTH;
        end
        if (wv) begin
            m_cnt[wid]++;
            if (wl) m_last[wid] = 1;
        end
        if (sv) begin
            m_cnt[sid]--;
            if (se) m_err[sid] = 1;
        end
        @(negedge clk);
    endtask

    // one cycle with legal random inputs; p_* are percentages
    task automatic step_rand(int pa, int pi, int pl, int pr, int pe, int pb);
        int  wc[$];
        int  sc[$];
        bit  wv, sv;
        int  wid, sid;
        foreach (m_order[k]) begin
            if (!m_last[m_order[k]] && m_cnt[m_order[k]] < MAXO) wc.push_back(m_order[k]);
            if (m_cnt[m_order[k]] > 0) sc.push_back(m_order[k]);
        end
        wv = (wc.size() > 0) && (($urandom % 100) < pi);
        wid = wv ? wc[$urandom % wc.size()] : 0;
        sv = (sc.size() > 0) && (($urandom % 100) < pr);
        sid = sv ? sc[$urandom % sc.size()] : 0;
        step_fixed(($urandom % 100) < pa, PTR_W'($urandom), wv, wid, (($urandom % 100) < pl),
                   sv, sid, (($urandom % 100) < pe), (($urandom % 100) < pb), PTR_W'($urandom));
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_cnt[i] = 0; m_last[i] = 0; m_err[i] = 0; m_ptr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8", "alloc_ready after reset", alloc_ready, 1);
        chk("R8", "alloc_id after reset", alloc_id, 0);
        chk("R8", "ret_valid after reset", ret_valid, 0);
        @(negedge clk);

        // R2: fill the table, then offer one more allocation
        for (int i = 0; i < DEPTH + 1; i++)
            step_fixed(1, PTR_W'(16'hA000 + i), 0, 0, 0, 0, 0, 0, 0, '0);
        // finish each packet with one last write and its response, oldest last
        for (int i = 0; i < DEPTH; i++)
            step_fixed(0, '0, 1, i, 1, 0, 0, 0, 0, '0);
        for (int i = DEPTH - 1; i >= 0; i--)
            step_fixed(0, '0, 0, 0, 0, 1, i, (i == 1), 0, '0);
        repeat (DEPTH + 1) step_fixed(0, '0, 0, 0, 0, 0, 0, 0, 1, 16'hBEEF);

        // R5: slot gets one write, then last write and a response together
        step_fixed(1, 16'h5555, 0, 0, 0, 0, 0, 0, 0, '0);
        step_fixed(0, '0, 1, m_order[0], 0, 0, 0, 0, 0, '0);
        step_fixed(0, '0, 1, m_order[0], 1, 1, m_order[0], 0, 0, '0);
        step_fixed(0, '0, 0, 0, 0, 0, 0, 0, 1, 16'h1234);
        chk("R5", "count held after paired issue/response", m_order.size(), 1);
        step_fixed(0, '0, 0, 0, 0, 1, m_order[0], 0, 1, 16'h4321);
        step_fixed(0, '0, 0, 0, 0, 0, 0, 0, 1, 16'h7777);

        // random phases: balanced, response-heavy, issue-heavy, error-rich
        repeat (800) step_rand(50, 50, 30, 50, 5, 30);
        repeat (800) step_rand(70, 30, 50, 80, 10, 50);
        repeat (800) step_rand(30, 80, 15, 30, 0, 10);
        repeat (800) step_rand(60, 60, 40, 60, 40, 70);
        // drain
        repeat (300) step_rand(0, 60, 60, 90, 0, 20);

        finish_run();
    end

endmodule